// File: doc/BRIEF.md
# Paired-Width Floating-Point Register File

This block holds the floating-point register state of a processor as raw 32-bit words. Each access carries a width code. A single-width access touches one word. A double-width access treats two neighbouring words as one 64-bit value, and the word at the higher index holds the upper half. A double-width write updates both words on the same clock edge.

Five 32-bit control and status registers follow the 32 architectural registers in the same index space. An instruction decoder can therefore reach them with the same index and width fields it uses for data registers. The block has two combinational read ports, one synchronous write port, a synchronous clear and a single fault flag. The flag goes high when any port presents an access that is not allowed. A disallowed write changes nothing.

Top module: `fpr_pair_file`

## Requirements
- R1: After reset every entry, from index 0 through index 36, reads as zero.
- R2: A read with width code 0 (single) at index n returns entry n on bits [31:0] and zero on bits [63:32].
- R3: A read with width code 1 (double) at index n returns entry n+1 on bits [63:32] and entry n on bits [31:0].
- R4: A single-width write at index n, with n at most 36, changes entry n and leaves every other entry as it was.
- R5: A double-width write at index n, with n at most 30, stores data bits [63:32] in entry n+1 and bits [31:0] in entry n on the same clock edge.
- R6: Indices 32 to 36 hold the control words in this order: identification, condition codes, exception flags, enables, control/status. Each is readable and writable with single width, and writing one leaves its neighbours unchanged.
- R7: A double-width access at index 31 or above is illegal. It raises fault, a read returns zero, and a write modifies no entry.
- R8: Width codes 2 and 3 are illegal. They raise fault, a read returns zero, and a write modifies no entry.
- R9: When clr is high at a clock edge, every entry, the control words included, becomes zero. This holds even if a write is presented in the same cycle.
- R10: Reads are combinational. In the cycle in which a write is presented, a read of the target index still returns the value from before the write.
- R11: A single-width access at index 37 or above is illegal. It raises fault, a read returns zero, and a write modifies no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; zeroes all entries |
| clr | input | 1 | Synchronous clear of all entries; takes priority over a write |
| rd0_idx | input | 6 | Read port 0 index |
| rd0_wid | input | 2 | Read port 0 width code (0 single, 1 double) |
| rd0_data | output | 64 | Read port 0 data |
| rd1_idx | input | 6 | Read port 1 index |
| rd1_wid | input | 2 | Read port 1 width code |
| rd1_data | output | 64 | Read port 1 data |
| wr_en | input | 1 | Write request |
| wr_idx | input | 6 | Write index |
| wr_wid | input | 2 | Write width code |
| wr_data | input | 64 | Write data; only bits [31:0] are used for a single-width write |
| fault | output | 1 | High while any read port, or an enabled write, presents an illegal access |

## Verification
Read data and fault are combinational, so they are due in the same cycle the inputs are presented. A write becomes visible only after the next rising edge. The driver changes inputs just after a falling edge and signals the monitor 2 ns later, well before the next rising edge. Each write is followed by reads in later cycles that compare against a model updated at that rising edge. During the write cycle itself, a read of the target index checks that the old value is still returned and that fault is correct.

// File: rtl/fpr_pair_file.sv
module fpr_pair_file #(
  parameter int ARCH_REGS = 32,
  parameter int CTRL_REGS = 5,
  parameter int IDX_W     = 6,
  parameter int WORD_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic [IDX_W-1:0]    rd0_idx,
  input  logic [1:0]          rd0_wid,
  output logic [2*WORD_W-1:0] rd0_data,
  input  logic [IDX_W-1:0]    rd1_idx,
  input  logic [1:0]          rd1_wid,
  output logic [2*WORD_W-1:0] rd1_data,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [1:0]          wr_wid,
  input  logic [2*WORD_W-1:0] wr_data,
  output logic                fault
);

  localparam int TOTAL = ARCH_REGS + CTRL_REGS;
  localparam logic [1:0] W_SGL = 2'd0;
  localparam logic [1:0] W_DBL = 2'd1;

  logic [TOTAL-1:0][WORD_W-1:0] store;
  logic [IDX_W-1:0] wr_hi;
  logic rd0_ok, rd1_ok, wr_ok;

  function automatic logic legal(input logic [IDX_W-1:0] i, input logic [1:0] w);
    case (w)
      W_SGL:   legal = int'(i) < TOTAL;
      W_DBL:   legal = int'(i) + 1 < ARCH_REGS;
      default: legal = 1'b0;
    endcase
  endfunction

  function automatic logic [2*WORD_W-1:0] fetch(input logic [TOTAL-1:0][WORD_W-1:0] s,
                                                input logic [IDX_W-1:0] i,
                                                input logic [1:0] w);
    logic [IDX_W-1:0] j;
    fetch = '0;
    j = i + 1'b1;
    if (legal(i, w)) begin
      fetch[WORD_W-1:0] = s[i];
      if (w == W_DBL) fetch[2*WORD_W-1:WORD_W] = s[j];
    end
  endfunction

  assign rd0_ok   = legal(rd0_idx, rd0_wid);
  assign rd1_ok   = legal(rd1_idx, rd1_wid);
  assign wr_ok    = legal(wr_idx, wr_wid);
  assign wr_hi    = wr_idx + 1'b1;
  assign rd0_data = fetch(store, rd0_idx, rd0_wid);
  assign rd1_data = fetch(store, rd1_idx, rd1_wid);
  assign fault    = !rd0_ok || !rd1_ok || (wr_en && !wr_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store <= '0;
    end else if (clr) begin
      store <= '0;
    end else if (wr_en && wr_ok) begin
      store[wr_idx] <= wr_data[WORD_W-1:0];
      if (wr_wid == W_DBL) store[wr_hi] <= wr_data[2*WORD_W-1:WORD_W];
    end
  end

endmodule

// File: rtl/fpr_pair_file_chk.sv
module fpr_pair_file_chk #(
  parameter int ARCH_REGS = 32,
  parameter int CTRL_REGS = 5,
  parameter int IDX_W     = 6,
  parameter int WORD_W    = 32
) (
  input logic                                      clk,
  input logic                                      rst_n,
  input logic                                      clr,
  input logic [1:0]                                rd0_wid,
  input logic [2*WORD_W-1:0]                       rd0_data,
  input logic                                      wr_en,
  input logic [IDX_W-1:0]                          wr_idx,
  input logic [1:0]                                wr_wid,
  input logic [2*WORD_W-1:0]                       wr_data,
  input logic                                      fault,
  input logic [ARCH_REGS+CTRL_REGS-1:0][WORD_W-1:0] store
);

  AST_SINGLE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_wid == 2'd0) |-> (rd0_data[2*WORD_W-1:WORD_W] == '0)); // R2

  AST_DBL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr && wr_wid == 2'd1 && int'(wr_idx) + 1 < ARCH_REGS)
    |=> ({store[$past(wr_idx) + IDX_W'(1)], store[$past(wr_idx)]} == $past(wr_data))); // R5

  AST_DBL_RANGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr && wr_wid == 2'd1 && int'(wr_idx) + 1 >= ARCH_REGS)
    |=> (store == $past(store))); // R7

  AST_BAD_WID_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_wid[1]) |-> fault); // R8

  AST_BAD_WID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr && wr_wid[1]) |=> (store == $past(store))); // R8

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (store == '0)); // R9

endmodule

bind fpr_pair_file fpr_pair_file_chk #(
  .ARCH_REGS(ARCH_REGS), .CTRL_REGS(CTRL_REGS), .IDX_W(IDX_W), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .rd0_wid(rd0_wid), .rd0_data(rd0_data),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_wid(wr_wid), .wr_data(wr_data),
  .fault(fault), .store(store)
);

// File: tb/fpr_pair_file_test.sv
module fpr_pair_file_test;
  localparam int TOTAL = 37;
  localparam int ARCH  = 32;

  logic        clk = 0, rst_n = 0, clr = 0, wr_en = 0;
  logic [5:0]  rd0_idx = 0, rd1_idx = 0, wr_idx = 0;
  logic [1:0]  rd0_wid = 0, rd1_wid = 0, wr_wid = 0;
  logic [63:0] wr_data = 0, rd0_data, rd1_data;
  logic        fault;

  fpr_pair_file uut (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .rd0_idx(rd0_idx), .rd0_wid(rd0_wid), .rd0_data(rd0_data),
    .rd1_idx(rd1_idx), .rd1_wid(rd1_wid), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_wid(wr_wid), .wr_data(wr_data),
    .fault(fault)
  );

  always #10 clk = ~clk;

  typedef struct {
    int          port;
    logic [63:0] data;
    logic        flt;
    string       tag;
  } item_t;

  item_t       q[$];
  event        ev;
  int          checks = 0, errors = 0;
  bit          done = 0;
  logic [31:0] mdl [TOTAL];

  function automatic bit ok(int idx, int wid);
    if (wid == 0) return idx < TOTAL;
    if (wid == 1) return idx + 1 < ARCH;
    return 0;
  endfunction

  function automatic logic [63:0] exp_rd(int idx, int wid);
    if (!ok(idx, wid)) return 64'h0;
    if (wid == 0) return {32'h0, mdl[idx]};
    return {mdl[idx+1], mdl[idx]};
  endfunction

  initial begin
    forever begin
      @(ev);
      while (q.size() > 0) begin
        item_t it;
        logic [63:0] got;
        it  = q.pop_front();
        got = (it.port == 0) ? rd0_data : rd1_data;
        checks++;
        if (got !== it.data || fault !== it.flt) begin
          errors++;
          $display("FAIL %s: data %h fault %b, expected data %h fault %b",
                   it.tag, got, fault, it.data, it.flt);
        end
      end
    end
  end

  task automatic rd(input int port, input int idx, input int wid, input string tag);
    item_t it;
    if (port == 0) begin
      rd0_idx = 6'(idx); rd0_wid = 2'(wid); rd1_idx = 0; rd1_wid = 0;
    end else begin
      rd1_idx = 6'(idx); rd1_wid = 2'(wid); rd0_idx = 0; rd0_wid = 0;
    end
    it.port = port; it.data = exp_rd(idx, wid); it.flt = !ok(idx, wid); it.tag = tag;
    q.push_back(it);
    #2 -> ev;
    #1;
    @(negedge clk);
  endtask

  task automatic wr(input int idx, input int wid, input logic [63:0] d,
                    input string tag, input bit with_clr = 0);
    item_t it;
    wr_en = 1; wr_idx = 6'(idx); wr_wid = 2'(wid); wr_data = d; clr = with_clr;
    rd0_idx = 6'(idx); rd0_wid = 0; rd1_idx = 0; rd1_wid = 0;
    it.port = 0; it.data = exp_rd(idx, 0);
    it.flt = !ok(idx, wid) || !ok(idx, 0);
    it.tag = {tag, "/R10"};
    q.push_back(it);
    #2 -> ev;
    #1;
    @(posedge clk);
    if (with_clr) begin
      for (int i = 0; i < TOTAL; i++) mdl[i] = 0;
    end else if (ok(idx, wid)) begin
      mdl[idx] = d[31:0];
      if (wid == 1) mdl[idx+1] = d[63:32];
    end
    @(negedge clk);
    wr_en = 0; clr = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < TOTAL; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < TOTAL; i++) rd(i % 2, i, 0, "R1 reset");

    wr(5, 0, 64'hDEAD_BEEF_A5A5_0001, "R4 single write");
    rd(0, 5, 0, "R4/R2 single read");
    rd(1, 4, 0, "R4 lower neighbour");
    rd(1, 6, 0, "R4 upper neighbour");
    wr(7, 0, 64'h0000_0000_7777_0007, "R4 single write");
    rd(1, 6, 1, "R3 double read");

    wr(10, 1, 64'h1122_3344_5566_7788, "R5 double write");
    rd(0, 10, 0, "R5 lower word");
    rd(1, 11, 0, "R5 upper word");
    rd(0, 10, 1, "R3 double read");
    rd(1, 9, 1, "R3 straddling pair");
    wr(30, 1, 64'hCAFE_0031_BABE_0030, "R5 last legal pair");
    rd(0, 30, 1, "R3 last legal pair");

    wr(31, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R7 double at 31");
    rd(0, 31, 0, "R7 entry 31 kept");
    rd(1, 32, 0, "R7 entry 32 kept");
    rd(0, 31, 1, "R7 double read at 31");
    wr(33, 1, 64'h1234_5678_9ABC_DEF0, "R7 double at control");
    rd(1, 34, 1, "R7 double read at control");

    for (int i = 32; i < 37; i++) wr(i, 0, 64'(32'hC0DE_0000 + i), "R6 control write");
    for (int i = 32; i < 37; i++) rd(1, i, 0, "R6 control read");
    rd(0, 31, 0, "R6 arch neighbour kept");

    wr(12, 2, 64'h0BAD_0BAD_0BAD_0BAD, "R8 width code 2");
    wr(12, 3, 64'h0BAD_0BAD_0BAD_0BAD, "R8 width code 3");
    rd(0, 12, 0, "R8 entry kept");
    rd(1, 10, 2, "R8 read width code 2");
    rd(0, 10, 3, "R8 read width code 3");

    wr(40, 0, 64'h0000_0000_5151_5151, "R11 index 40");
    rd(0, 37, 0, "R11 read index 37");
    rd(1, 63, 0, "R11 read index 63");

    wr(15, 0, 64'h0000_0000_1515_1515, "R9 clear beats write", 1);
    rd(0, 15, 0, "R9 write lost to clear");
    rd(1, 10, 1, "R9 data cleared");
    rd(0, 36, 0, "R9 control cleared");
    rd(1, 5, 0, "R9 data cleared");

    wr(20, 0, 64'h0000_0000_2020_2020, "R4 after clear");
    rd(0, 20, 0, "R4 after clear");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule